// File: doc/BRIEF.md
# Ring-Pointer Register FIFO

This block is a small register-based first-in, first-out queue that sits between a producer and a consumer running in the same clock domain. It lets the two sides move data at different rates, and it keeps words in strict arrival order. The producer cannot pick a slot and neither can the consumer. Each word goes into the next slot the block chooses, and each word leaves from the oldest occupied slot.

Slot choice is done without any binary address. The write position and the read position are each a one-hot ring register that moves left by one place on every accepted transfer and wraps from the top slot to slot 0. The write ring enables the storage register it points at. The read ring gates the slots into an AND-OR tree that forms the output word. An occupancy counter tells a full queue from an empty one, because the two rings are equal in both cases.

Both ports use a valid/ready handshake. The head word is shown on the read port while the queue holds data, so the consumer sees it in the same cycle it is offered.

Top module: `onehot_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `rdValid` is 0 and `wrReady` is 1.
- R2: Words leave in exactly the order in which they were accepted.
- R3: After DEPTH accepted writes with no reads, `full` is 1 and `empty` is 0.
- R4: A write offered while full, with `rdReady` low, is refused (`wrReady` is 0). It changes neither the stored words nor the occupancy.
- R5: A read attempt while empty has no effect. `rdValid` stays 0 and no later word is lost or duplicated.
- R6: When full, a write and a read in the same cycle are both accepted, and the queue stays full.
- R7: At partial occupancy, a write and a read in the same cycle leave the occupancy unchanged.
- R8: The slot positions wrap from the top slot back to slot 0, so ordering holds across more than DEPTH transfers.
- R9: `rdValid` equals the inverse of `empty`. While `rdValid` is 1, `rdData` is the oldest stored word, and it is valid in the cycle after the write that stored it.
- R10: While `rdValid` is 1 and `rdReady` is 0, `rdData` and `rdValid` stay unchanged into the next cycle, even if a write is accepted.
- R11: `wrReady` is 1 exactly when the queue is not full or `rdReady` is 1.
- R12: `full` and `empty` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wrValid | input | 1 | Producer offers a word |
| wrData | input | DATA_W | Word offered by the producer |
| wrReady | output | 1 | Queue accepts the offered word this cycle |
| rdValid | output | 1 | A word is available on rdData |
| rdData | output | DATA_W | Oldest stored word |
| rdReady | input | 1 | Consumer takes the word this cycle |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |

## Verification
`wrReady` is a combinational function of the occupancy and `rdReady`, so it is due in the same cycle as the read request. `full`, `empty`, `rdValid` and `rdData` change one clock after the edge that accepts a transfer, since only the counter, the rings and the slot registers sit on that path. The bench drives every input just after a falling edge. It samples all outputs a nanosecond later, before the next rising edge, so each check sees the state left by the previous edge together with the current request. The expected state comes from a queue model kept in the bench, and it is updated after the rising edge according to the acceptance rules.

// File: rtl/onehot_fifo_pkg.sv
package onehot_fifo_pkg;

  // Strobes from control to datapath: one accepted write, one accepted read.
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;

endpackage

// File: rtl/onehot_ring.sv
module onehot_ring #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  output logic [N-1:0] ptr
);

  logic [N-1:0] nextPtr;

  generate
    if (N == 1) begin : g_single
      assign nextPtr = ptr;
    end else begin : g_rotate
      assign nextPtr = {ptr[N-2:0], ptr[N-1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= {{(N-1){1'b0}}, 1'b1};
    end else if (advance) begin
      ptr <= nextPtr;
    end
  end

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import onehot_fifo_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrValid,
  input  logic        rdReady,
  output logic        wrReady,
  output logic        rdValid,
  output logic        full,
  output logic        empty,
  output fifoStrobe_t strobe
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] occupancy;

  assign full    = (occupancy == CNT_MAX);
  assign empty   = (occupancy == '0);
  assign rdValid = !empty;
  // When full, a same-cycle read frees a slot, so the write may proceed.
  assign wrReady = !full || rdReady;

  assign strobe.push = wrValid && wrReady;
  assign strobe.pop  = rdReady && rdValid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occupancy <= '0;
    end else begin
      unique case ({strobe.push, strobe.pop})
        2'b10:   occupancy <= occupancy + CNT_ONE;
        2'b01:   occupancy <= occupancy - CNT_ONE;
        default: occupancy <= occupancy;
      endcase
    end
  end

endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import onehot_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DEPTH-1:0]  wrRing;
  logic [DEPTH-1:0]  rdRing;
  logic [DATA_W-1:0] slot [DEPTH];

  onehot_ring #(.N(DEPTH)) u_wrRing (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (strobe.push),
    .ptr     (wrRing)
  );

  onehot_ring #(.N(DEPTH)) u_rdRing (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (strobe.pop),
    .ptr     (rdRing)
  );

  // Each slot loads only when the write ring points at it.
  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          slot[s] <= '0;
        end else if (strobe.push && wrRing[s]) begin
          slot[s] <= wrData;
        end
      end
    end
  endgenerate

  // AND-OR selection gated by the read ring; no binary decode.
  always_comb begin
    rdData = '0;
    for (int s = 0; s < DEPTH; s++) begin
      rdData = rdData | (slot[s] & {DATA_W{rdRing[s]}});
    end
  end

endmodule

// File: rtl/onehot_fifo.sv
module onehot_fifo
  import onehot_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  input  logic              rdReady,
  output logic              full,
  output logic              empty
);

  fifoStrobe_t strobe;

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrValid (wrValid),
    .rdReady (rdReady),
    .wrReady (wrReady),
    .rdValid (rdValid),
    .full    (full),
    .empty   (empty),
    .strobe  (strobe)
  );

  fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: rtl/onehot_fifo_checker.sv
module onehot_fifo_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrValid,
  input logic              wrReady,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              rdReady,
  input logic              full,
  input logic              empty
);

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_valid_tracks_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid == !empty);

  assert_ready_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wrReady == (!full || rdReady));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rdReady) |=> full);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wrValid) |=> empty);

  assert_full_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rdReady && wrValid) |=> full);

  assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

endmodule

bind onehot_fifo onehot_fifo_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wrValid (wrValid),
  .wrReady (wrReady),
  .rdValid (rdValid),
  .rdData  (rdData),
  .rdReady (rdReady),
  .full    (full),
  .empty   (empty)
);

// File: tb/sim_onehot_fifo.sv
`timescale 1ns/1ps
module sim_onehot_fifo;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int NVEC   = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wrValid = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              wrReady;
  logic              rdValid;
  logic [DATA_W-1:0] rdData;
  logic              rdReady = 1'b0;
  logic              full;
  logic              empty;

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] model [$];

  always #10 clk = ~clk;

  onehot_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrData(wrData),
    .wrReady(wrReady), .rdValid(rdValid), .rdData(rdData),
    .rdReady(rdReady), .full(full), .empty(empty)
  );

  // Vector fields: wv, wd[7:0], rr | expected before the edge: empty, full, wrReady, dataChk, data[7:0]
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},  // R1 empty start
    {1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11},  // R9 head next cycle
    {1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11},  // R10 head holds
    {1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11},
    {1'b1, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11},  // R3 full, R4 refused
    {1'b1, 8'h66, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h11},  // R6 swap when full
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h22},  // R6 still full
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h33},
    {1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h44},  // R7 swap partial
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h66},  // R4 55 absent
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h77},  // R8 wrapped slot
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},  // R5 read when empty
    {1'b1, 8'h88, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},  // R5 write only taken
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h88},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h88},  // R2 single word
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle against the queue model: drive, sample, clock, update model.
  task automatic step(input logic wv, input logic [DATA_W-1:0] wd, input logic rr);
    bit pushOk, popOk;
    @(negedge clk);
    wrValid = wv; wrData = wd; rdReady = rr;
    #1;
    check("R9",  "rdValid", rdValid, model.size() > 0);
    check("R3",  "full",    full,    model.size() == DEPTH);
    check("R12", "empty",   empty,   model.size() == 0);
    check("R11", "wrReady", wrReady, (model.size() < DEPTH) || rr);
    if (model.size() > 0) check("R2", "rdData", rdData, model[0]);
    pushOk = wv && ((model.size() < DEPTH) || rr);
    popOk  = rr && (model.size() > 0);
    @(posedge clk);
    if (popOk)  void'(model.pop_front());
    if (pushOk) model.push_back(wd);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "empty",   empty,   1);
    check("R1", "full",    full,    0);
    check("R1", "rdValid", rdValid, 0);
    check("R1", "wrReady", wrReady, 1);

    // Vector table walk
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      wrValid = VEC[k][21]; wrData = VEC[k][20:13]; rdReady = VEC[k][12];
      #1;
      check("R12", $sformatf("v%0d empty", k), empty,   VEC[k][11]);
      check("R3",  $sformatf("v%0d full", k),  full,    VEC[k][10]);
      check("R11", $sformatf("v%0d wrReady", k), wrReady, VEC[k][9]);
      check("R9",  $sformatf("v%0d rdValid", k), rdValid, VEC[k][8]);
      if (VEC[k][8]) check("R2", $sformatf("v%0d rdData", k), rdData, VEC[k][7:0]);
    end

    // Directed: long stream with wrap (R8), mixed rates (R7), bursts
    for (int i = 0; i < 40; i++) step(1'b1, 8'(8'hA0 + i), (i % 3) == 0);
    for (int i = 0; i < 10; i++) step(1'b0, 8'h00, 1'b1);
    for (int i = 0; i < 60; i++) step((i % 2) == 0, 8'(i * 7), (i % 5) != 0);
    // Full drain with refused writes at full (R4)
    for (int i = 0; i < DEPTH + 3; i++) step(1'b1, 8'(8'hC0 + i), 1'b0);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 8'h00, 1'b1);
    // Empty read attempts (R5)
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b1);
    check("R5", "model empty", model.size(), 0);

    // Mid-run reset returns to R1 state
    @(negedge clk);
    wrValid = 1'b1; wrData = 8'h5A; rdReady = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; wrValid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "empty after reset", empty, 1);
    check("R1", "rdValid after reset", rdValid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule